// File: doc/BRIEF.md
# Programmable Baud Divisor Generator

This block divides a reference clock by a programmable 16-bit divisor. It produces the 16x oversampling rate for a UART's transmitter and receiver. Software writes the divisor one byte at a time into a low latch and a high latch. Each write restarts the period at once, so a change of rate never waits out a long count left over from an old divisor.

The block has two outputs. `baud_out` is a waveform with one period per divided cycle. `baud_tick` is a one-cycle pulse at the start of each period, and the shifters downstream use it as a clock enable.

Divisor values 0, 1 and 2 take special shapes. Any value of 3 or more gives a period of that many reference cycles: 2 cycles low, and high for the rest of the period.

A three-state phase machine drives both outputs:
- States: `PH_FOLLOW` (divisor 1), `PH_LOW` (low phase) and `PH_HIGH` (high phase).
- Transitions:
  - `reload` (any latch write) enters `PH_FOLLOW` or `PH_LOW`.
  - `low_to_high` fires when the count drops to or below the low threshold.
  - `wrap` goes to `PH_LOW` when the count reaches 1.
  - `follow_hold` keeps `PH_FOLLOW` on every cycle.

Top module: `baud_divgen`

## Requirements
- R1: Reset clears both latches to 0. From reset release the outputs follow the divisor-0 pattern, starting at the first cycle of a period.
- R2: A write with `wr_sel`=0 loads bits 7:0 of the divisor. A write with `wr_sel`=1 loads bits 15:8. The other latch keeps its value.
- R3: In the cycle after a latch write, a new period begins (`baud_tick`=1, `baud_out`=0 unless the divisor is 1). The old count is discarded.
- R4: Divisor 0 gives a period of 3 cycles: `baud_out` low for 2 cycles, then high for 1.
- R5: Divisor 1 holds `baud_out` at 1 and asserts `baud_tick` on every reference cycle.
- R6: Divisor 2 gives a period of 2 cycles: `baud_out` low for 1 cycle, then high for 1.
- R7: A divisor N of 3 or more gives a period of N cycles: `baud_out` low for the first 2 cycles and high for N-2.
- R8: For a divisor of 0 or 2 or more, `baud_tick` is 1 only in the first cycle of each period, while `baud_out` is low.
- R9: The largest divisor, 65535, gives a period of 65535 cycles with one tick at each period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Latch write strobe |
| wr_sel | input | 1 | Latch select: 0 low byte, 1 high byte |
| wr_data | input | 8 | Byte to write |
| baud_out | output | 1 | Divided waveform |
| baud_tick | output | 1 | One-cycle pulse at each period start |

## Verification
The bench builds the block with its defaults: two 8-bit latches forming a 16-bit divisor. With this setting, the divide-by-3 reset pattern, each special divisor value and the full 65535-cycle period can all be observed.

The bench also changes the divisor one byte at a time in the middle of a 300-cycle period. This shows that each byte write restarts the count on the mixed divisor at once, instead of finishing the old period first.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;

    typedef enum logic [1:0] {
        PH_FOLLOW = 2'd0,
        PH_LOW    = 2'd1,
        PH_HIGH   = 2'd2
    } phase_e;

    localparam int unsigned LOW_CYCLES = 2;

endpackage

// File: rtl/baud_div_latches.sv
module baud_div_latches #(
    parameter int LATCH_W   = 8,
    parameter int NUM_LATCH = 2,
    parameter int SEL_W     = 1,
    localparam int DIV_W    = LATCH_W * NUM_LATCH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [LATCH_W-1:0] wr_data,
    output logic [DIV_W-1:0]   div_cur,
    output logic [DIV_W-1:0]   div_next,
    output logic               reload
);

    assign reload = wr_en;

    for (genvar i = 0; i < NUM_LATCH; i++) begin : g_latch
        logic [LATCH_W-1:0] byte_q;
        logic               hit;

        assign hit = wr_en && (wr_sel == SEL_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (hit) begin
                byte_q <= wr_data;
            end
        end

        assign div_cur[i*LATCH_W +: LATCH_W]  = byte_q;
        assign div_next[i*LATCH_W +: LATCH_W] = hit ? wr_data : byte_q;
    end

endmodule

// File: rtl/baud_div_decode.sv
module baud_div_decode #(
    parameter int DIV_W = 16
) (
    input  logic [DIV_W-1:0] div_val,
    output logic [DIV_W-1:0] period,
    output logic [1:0]       low_len,
    output logic             follow
);

    localparam logic [DIV_W-1:0] ZERO_PERIOD = DIV_W'(3);
    localparam logic [DIV_W-1:0] ONE         = DIV_W'(1);
    localparam logic [DIV_W-1:0] TWO         = DIV_W'(2);

    always_comb begin
        period  = div_val;
        low_len = 2'(baud_div_pkg::LOW_CYCLES);
        follow  = 1'b0;
        if (div_val == '0) begin
            period = ZERO_PERIOD;
        end else if (div_val == ONE) begin
            low_len = 2'd0;
            follow  = 1'b1;
        end else if (div_val == TWO) begin
            low_len = 2'd1;
        end
    end

endmodule

// File: rtl/baud_div_sequencer.sv
module baud_div_sequencer
    import baud_div_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [DIV_W-1:0] per_in,
    input  logic [1:0]       low_in,
    input  logic             follow_in,
    output logic             baud_out,
    output logic             baud_tick
);

    localparam logic [DIV_W-1:0] RST_PERIOD = DIV_W'(3);
    localparam logic [DIV_W-1:0] ONE        = DIV_W'(1);

    phase_e           st_q, st_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [DIV_W-1:0] per_q, per_d;
    logic [1:0]       low_q, low_d;
    logic [DIV_W-1:0] dec;
    logic [DIV_W-1:0] thresh;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PH_LOW;
            cnt_q <= RST_PERIOD;
            per_q <= RST_PERIOD;
            low_q <= 2'(LOW_CYCLES);
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            per_q <= per_d;
            low_q <= low_d;
        end
    end

    assign dec    = cnt_q - ONE;
    assign thresh = per_q - DIV_W'(low_q);

    // next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        per_d = per_q;
        low_d = low_q;
        if (reload) begin
            per_d = per_in;
            low_d = low_in;
            cnt_d = per_in;
            st_d  = follow_in ? PH_FOLLOW : PH_LOW;
        end else begin
            unique case (st_q)
                PH_FOLLOW: begin
                    cnt_d = per_q;
                    st_d  = PH_FOLLOW;
                end
                PH_LOW, PH_HIGH: begin
                    if (cnt_q <= ONE) begin
                        cnt_d = per_q;
                        st_d  = PH_LOW;
                    end else begin
                        cnt_d = dec;
                        st_d  = (dec > thresh) ? PH_LOW : PH_HIGH;
                    end
                end
                default: begin
                    cnt_d = per_q;
                    st_d  = PH_LOW;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        baud_out  = 1'b0;
        baud_tick = 1'b0;
        unique case (st_q)
            PH_FOLLOW: begin
                baud_out  = 1'b1;
                baud_tick = 1'b1;
            end
            PH_LOW: begin
                baud_out  = 1'b0;
                baud_tick = (cnt_q == per_q);
            end
            PH_HIGH: begin
                baud_out  = 1'b1;
                baud_tick = 1'b0;
            end
            default: begin
                baud_out  = 1'b0;
                baud_tick = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/baud_divgen.sv
module baud_divgen #(
    parameter int LATCH_W   = 8,
    parameter int NUM_LATCH = 2,
    localparam int DIV_W    = LATCH_W * NUM_LATCH,
    localparam int SEL_W    = (NUM_LATCH > 1) ? $clog2(NUM_LATCH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [LATCH_W-1:0] wr_data,
    output logic               baud_out,
    output logic               baud_tick
);

    logic [DIV_W-1:0] div_cur;
    logic [DIV_W-1:0] div_next;
    logic             reload;
    logic [DIV_W-1:0] per_n;
    logic [1:0]       low_n;
    logic             follow_n;

    baud_div_latches #(
        .LATCH_W   (LATCH_W),
        .NUM_LATCH (NUM_LATCH),
        .SEL_W     (SEL_W)
    ) u_latches (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .div_cur  (div_cur),
        .div_next (div_next),
        .reload   (reload)
    );

    baud_div_decode #(
        .DIV_W (DIV_W)
    ) u_decode (
        .div_val (div_next),
        .period  (per_n),
        .low_len (low_n),
        .follow  (follow_n)
    );

    baud_div_sequencer #(
        .DIV_W (DIV_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload    (reload),
        .per_in    (per_n),
        .low_in    (low_n),
        .follow_in (follow_n),
        .baud_out  (baud_out),
        .baud_tick (baud_tick)
    );

endmodule

// File: rtl/baud_divgen_chk.sv
module baud_divgen_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [DIV_W-1:0] div_cur,
    input logic             baud_out,
    input logic             baud_tick
);

    AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> baud_tick); // R3

    AST_DIV1_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (div_cur == DIV_W'(1)) |-> (baud_tick && baud_out)); // R5

    AST_TICK_HIGH_ONLY_DIV1: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_tick && baud_out) |-> (div_cur == DIV_W'(1))); // R8

    AST_DIV2_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (div_cur == DIV_W'(2) && !wr_en) |=> (baud_out != $past(baud_out))); // R6

    AST_LOW_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_tick && div_cur >= DIV_W'(3) && !wr_en) |=> (!baud_out && !baud_tick)); // R7

endmodule

bind baud_divgen baud_divgen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .div_cur   (div_cur),
    .baud_out  (baud_out),
    .baud_tick (baud_tick)
);

// File: tb/baud_divgen_bench.sv
`timescale 1ns/1ps
module baud_divgen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [0:0] wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       baud_out;
    logic       baud_tick;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] mdl_div = 16'h0000;

    typedef struct {
        logic  out;
        logic  tick;
        int    k;
        string tag;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;

    baud_divgen u_baud_divgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .baud_out  (baud_out),
        .baud_tick (baud_tick)
    );

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_tests++;
                if (baud_out !== e.out || baud_tick !== e.tick) begin
                    n_fail++;
                    $display("FAIL %s k=%0d: out/tick actual %b/%b expected %b/%b",
                             e.tag, e.k, baud_out, baud_tick, e.out, e.tick);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic do_write(input logic sel, input logic [7:0] data);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        if (sel) mdl_div[15:8] = data;
        else     mdl_div[7:0]  = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: pushes expected items for n cycles from period start
    task automatic expect_run(input int n, input string tag);
        int per;
        int lowl;
        per  = (mdl_div == 0) ? 3 : int'(mdl_div);
        lowl = (per == 1) ? 0 : ((per == 2) ? 1 : 2);
        for (int k = 0; k < n; k++) begin
            exp_t e;
            int pos;
            pos    = k % per;
            e.k    = k;
            e.tag  = tag;
            e.tick = (per == 1) ? 1'b1 : (pos == 0);
            e.out  = (pos >= lowl);
            q.push_back(e);
        end
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // reset state (R1)
        n_tests++;
        if (baud_out !== 1'b0 || baud_tick !== 1'b1) begin
            n_fail++;
            $display("FAIL R1 in reset: out/tick actual %b/%b expected 0/1", baud_out, baud_tick);
        end
        rst_n = 1'b1;
        expect_run(9, "R1");

        do_write(1'b0, 8'd7);
        expect_run(21, "R7");
        do_write(1'b0, 8'd2);
        expect_run(8, "R6");
        do_write(1'b0, 8'd1);
        expect_run(6, "R5");
        do_write(1'b0, 8'd0);
        expect_run(9, "R4");
        do_write(1'b0, 8'd3);
        expect_run(12, "R8");

        // R2: high byte then low byte -> 0x012C = 300
        do_write(1'b1, 8'h01);
        do_write(1'b0, 8'h2C);
        expect_run(40, "R2");

        // R3: mid-period write of low byte gives 0x0105 at once
        do_write(1'b0, 8'h05);
        expect_run(270, "R3");
        do_write(1'b1, 8'h00);
        expect_run(15, "R3");

        // R9: maximum divisor
        do_write(1'b1, 8'hFF);
        do_write(1'b0, 8'hFF);
        expect_run(65540, "R9");

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule